// File: doc/BRIEF.md
# Multi-Granule Translation Table Walker

This block turns a 48-bit virtual address into a physical address by walking a tree of in-memory translation tables. A caller supplies the virtual address, the address of the first table, a granule code (4 KB, 16 KB or 64 KB), a six-bit input-size field and a stage flag. The walker then fetches 64-bit descriptors through a plain request/response read port, one read at a time, until it reaches a leaf or a fault.

On completion it raises `done_o` for exactly one cycle. With it come the physical address, the page mask that applies to the mapping (ones above the page offset), a writable flag and a fault flag. The granule decides three things: which level the walk starts at, which slice of the virtual address indexes each table, and which levels may hold leaves. The contiguous hint in a leaf widens the page mask.

The control is a five-state machine:
- **ST_IDLE**: waits for `start_i`. An unusable granule code or size field goes straight to **ST_DONE** with a fault. Anything else goes to **ST_READ_REQ**.
- **ST_READ_REQ**: issues one read, then moves to **ST_READ_WAIT**.
- **ST_READ_WAIT**: waits for `rd_ack_i`, then moves to **ST_DECODE**.
- **ST_DECODE**: finishes in **ST_DONE** on an error, an invalid descriptor or a leaf. On a table descriptor it goes back to **ST_READ_REQ** one level deeper.
- **ST_DONE**: pulses `done_o` and returns to **ST_IDLE**.

Top module: `xlat_walker`

## Requirements
- R1: The start level follows from granule code and size field. For granule 0 (4 KB), 16–24 gives level 0, 25–33 gives level 1 and 34–39 gives level 2. For granule 1 (16 KB), 16 gives level 0, 17–27 gives level 1, 28–38 gives level 2 and 39 gives level 3. For granule 2 (64 KB), 12–21 gives level 1, 22–34 gives level 2 and 35–39 gives level 3. Any other size or granule code 3 ends the walk with a fault one cycle after start, with no read.
- R2: Each read address is the current table address plus 8 times the table index. The index is taken from VA bits as follows. For 4 KB, levels 0..3 use [47:39], [38:30], [29:21] and [20:12]. For 16 KB, they use [47], [46:36], [35:25] and [24:14]. For 64 KB, levels 1..3 use [47:42], [41:29] and [28:16]. The base must be 8-byte aligned.
- R3: A descriptor is invalid when bit 0 is clear. At level 3 it is also invalid when bit 1 is clear. An invalid descriptor ends the walk with a fault.
- R4: A descriptor at level 0 is never a leaf, and neither is one at level 1 under 16 KB or 64 KB. Such descriptors are followed as tables whatever bit 1 holds. At levels 1–2 elsewhere, bit 1 clear marks a leaf. Level 3 is always a leaf.
- R5: A table descriptor's bits [47:s], with the lower bits zeroed, give the next table address. Here s is 12, 14 or 16 for the three granules.
- R6: For a leaf, the page mask covers bits [47:w]. The PA takes bits under the mask from the descriptor and the remaining bits from the VA. Without the contiguous hint, w is the level's index low bit (4 KB: 30/21/12, 16 KB: 36/25/14, 64 KB: 29/16 at levels 1/2/3 and 2/3).
- R7: Descriptor bit 52 set widens w. It becomes 16 for 4 KB level 3, 30 for 16 KB level 2, 21 for 16 KB level 3 and 21 for 64 KB level 3. Elsewhere bit 52 has no effect.
- R8: In stage-1 mode a leaf is writable when bit 7 is 0. In stage-2 mode it is writable when bits [7:6] are 2'b11.
- R9: A read answered with `rd_err_i` ends the walk with a fault. Every fault returns zero PA, zero mask and not-writable.
- R10: Each read takes 2 + L cycles, where L is the response latency. `rd_req_o` is a one-cycle pulse and no new request is issued before the previous response. `done_o` rises N·(L+2)+1 cycles after the start edge for N reads and lasts one cycle.
- R11: `start_i` is ignored while a walk is in progress. It neither changes the running walk nor starts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 48 | Virtual address to translate |
| base_i | input | 48 | Address of the first table |
| gran_i | input | 2 | Granule: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = reserved |
| tsz_i | input | 6 | Input-size field selecting the start level |
| stage2_i | input | 1 | 1 = stage-2 writability rule |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 48 | Descriptor address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Descriptor data |
| rd_err_i | input | 1 | Read response error |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk failed (valid with done_o) |
| pa_o | output | 48 | Physical address (valid with done_o) |
| pmask_o | output | 48 | Page mask (valid with done_o) |
| wr_ok_o | output | 1 | Leaf is writable (valid with done_o) |

## Verification
Take the edge that samples `start_i` as cycle 0. The first request is high in cycle 1. A response driven L cycles after a request is decoded one cycle later, so each read costs L+2 cycles, and `done_o` is due in cycle N·(L+2)+1. A rejected configuration has its done in cycle 1. The bench sets the expected done cycle from its own walk model and the chosen latency. It samples on the falling edge and compares `done_o` against that cycle on every clock of the walk, plus four idle cycles after it. It checks each request address in the cycle the request is seen, and checks PA, mask, writable and fault flags in the done cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W     = 48;
    localparam int DESC_W   = 64;
    localparam int CONT_BIT = 52;
    localparam int LVL_W    = 2;
    localparam int SH_W     = 6;

    typedef enum logic [1:0] {
        GR_4K   = 2'd0,
        GR_16K  = 2'd1,
        GR_64K  = 2'd2,
        GR_RSVD = 2'd3
    } gran_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_DECODE,
        ST_DONE
    } state_e;

    // low bit of the VA slice that indexes a table at a level
    function automatic logic [SH_W-1:0] lvl_shift(gran_e g, logic [LVL_W-1:0] l);
        logic [SH_W-1:0] r;
        r = '0;
        unique case (g)
            GR_4K:  r = 6'(39 - 9 * int'(l));
            GR_16K: r = (l == 2'd0) ? 6'd47 : 6'(47 - 11 * int'(l));
            GR_64K: r = (l == 2'd0) ? 6'd0  : 6'(55 - 13 * int'(l));
            default: r = '0;
        endcase
        return r;
    endfunction

    // width of that slice
    function automatic logic [SH_W-1:0] lvl_width(gran_e g, logic [LVL_W-1:0] l);
        logic [SH_W-1:0] r;
        r = '0;
        unique case (g)
            GR_4K:  r = (l == 2'd0) ? 6'd9 : 6'd9;
            GR_16K: r = (l == 2'd0) ? 6'd1 : 6'd11;
            GR_64K: r = (l == 2'd0) ? 6'd0 : ((l == 2'd1) ? 6'd6 : 6'd13);
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xw_start_lvl.sv
module xw_start_lvl
    import xw_pkg::*;
(
    input  gran_e            gran,
    input  logic [5:0]       tsz,
    output logic [LVL_W-1:0] lvl,
    output logic             bad
);
    always_comb begin
        lvl = '0;
        bad = 1'b0;
        unique case (gran)
            GR_4K: begin
                if (tsz >= 6'd16 && tsz <= 6'd24)      lvl = 2'd0;
                else if (tsz >= 6'd25 && tsz <= 6'd33) lvl = 2'd1;
                else if (tsz >= 6'd34 && tsz <= 6'd39) lvl = 2'd2;
                else                                   bad = 1'b1;
            end
            GR_16K: begin
                if (tsz == 6'd16)                      lvl = 2'd0;
                else if (tsz >= 6'd17 && tsz <= 6'd27) lvl = 2'd1;
                else if (tsz >= 6'd28 && tsz <= 6'd38) lvl = 2'd2;
                else if (tsz == 6'd39)                 lvl = 2'd3;
                else                                   bad = 1'b1;
            end
            GR_64K: begin
                if (tsz >= 6'd12 && tsz <= 6'd21)      lvl = 2'd1;
                else if (tsz >= 6'd22 && tsz <= 6'd34) lvl = 2'd2;
                else if (tsz >= 6'd35 && tsz <= 6'd39) lvl = 2'd3;
                else                                   bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/xw_index.sv
module xw_index
    import xw_pkg::*;
#(
    parameter int AW = VA_W
) (
    input  logic [AW-1:0]    va,
    input  gran_e            gran,
    input  logic [LVL_W-1:0] lvl,
    output logic [AW-1:0]    byte_off
);
    logic [SH_W-1:0] sh;
    logic [SH_W-1:0] wd;
    logic [AW-1:0]   slice;

    always_comb begin
        sh       = lvl_shift(gran, lvl);
        wd       = lvl_width(gran, lvl);
        slice    = (va >> sh) & ~({AW{1'b1}} << wd);
        byte_off = slice << 3;
    end
endmodule

// File: rtl/xw_desc_dec.sv
module xw_desc_dec
    import xw_pkg::*;
#(
    parameter int AW = VA_W,
    parameter int DW = DESC_W
) (
    input  logic [DW-1:0]    desc,
    input  gran_e            gran,
    input  logic [LVL_W-1:0] lvl,
    input  logic             stage2,
    output logic             valid,
    output logic             leaf,
    output logic [AW-1:0]    next_tbl,
    output logic [SH_W-1:0]  mask_w,
    output logic             wr_ok
);
    logic [SH_W-1:0] gran_sh;
    logic            unused_hi;

    assign unused_hi = ^{desc[DW-1:CONT_BIT+1], desc[CONT_BIT-1:AW]};

    always_comb begin
        valid = desc[0] & ((lvl != 2'd3) | desc[1]);

        unique case (lvl)
            2'd0: leaf = 1'b0;
            2'd1: leaf = (gran == GR_4K) & ~desc[1];
            2'd2: leaf = ~desc[1];
            default: leaf = 1'b1;
        endcase

        gran_sh  = lvl_shift(gran, 2'd3);
        next_tbl = desc[AW-1:0] & ({AW{1'b1}} << gran_sh);

        mask_w = lvl_shift(gran, lvl);
        if (desc[CONT_BIT]) begin
            unique case (gran)
                GR_4K:   if (lvl == 2'd3) mask_w = 6'd16;
                GR_16K:  if (lvl == 2'd2) mask_w = 6'd30;
                         else if (lvl == 2'd3) mask_w = 6'd21;
                GR_64K:  if (lvl == 2'd3) mask_w = 6'd21;
                default: mask_w = mask_w;
            endcase
        end

        wr_ok = stage2 ? (desc[7:6] == 2'b11) : ~desc[7];
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W = VA_W,
    parameter int DATA_W = DESC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        gran_i,
    input  logic [5:0]        tsz_i,
    input  logic              stage2_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic [ADDR_W-1:0] pmask_o,
    output logic              wr_ok_o
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] va_q, tbl_q, pa_q, pmask_q;
    logic [DATA_W-1:0] desc_q;
    gran_e             gran_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              s2_q, err_q, fault_q, wr_q;

    logic [LVL_W-1:0]  first_lvl;
    logic              cfg_bad;
    logic [ADDR_W-1:0] off;
    logic              d_valid, d_leaf, d_wr;
    logic [ADDR_W-1:0] d_next;
    logic [SH_W-1:0]   d_mw;
    logic [ADDR_W-1:0] leaf_mask;

    xw_start_lvl u_start (
        .gran (gran_e'(gran_i)),
        .tsz  (tsz_i),
        .lvl  (first_lvl),
        .bad  (cfg_bad)
    );

    xw_index #(.AW(ADDR_W)) u_index (
        .va       (va_q),
        .gran     (gran_q),
        .lvl      (lvl_q),
        .byte_off (off)
    );

    xw_desc_dec #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
        .desc     (desc_q),
        .gran     (gran_q),
        .lvl      (lvl_q),
        .stage2   (s2_q),
        .valid    (d_valid),
        .leaf     (d_leaf),
        .next_tbl (d_next),
        .mask_w   (d_mw),
        .wr_ok    (d_wr)
    );

    assign leaf_mask = {ADDR_W{1'b1}} << d_mw;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = cfg_bad ? ST_DONE : ST_READ_REQ;
            ST_READ_REQ:  state_d = ST_READ_WAIT;
            ST_READ_WAIT: if (rd_ack_i) state_d = ST_DECODE;
            ST_DECODE:    state_d = (err_q || !d_valid || d_leaf) ? ST_DONE : ST_READ_REQ;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            tbl_q   <= '0;
            gran_q  <= GR_4K;
            lvl_q   <= '0;
            s2_q    <= 1'b0;
            desc_q  <= '0;
            err_q   <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
            pmask_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    va_q   <= va_i;
                    tbl_q  <= base_i;
                    gran_q <= gran_e'(gran_i);
                    lvl_q  <= first_lvl;
                    s2_q   <= stage2_i;
                    if (cfg_bad) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                        pmask_q <= '0;
                        wr_q    <= 1'b0;
                    end
                end
                ST_READ_WAIT: if (rd_ack_i) begin
                    desc_q <= rd_data_i;
                    err_q  <= rd_err_i;
                end
                ST_DECODE: begin
                    if (err_q || !d_valid) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                        pmask_q <= '0;
                        wr_q    <= 1'b0;
                    end else if (d_leaf) begin
                        fault_q <= 1'b0;
                        pa_q    <= (desc_q[ADDR_W-1:0] & leaf_mask) | (va_q & ~leaf_mask);
                        pmask_q <= leaf_mask;
                        wr_q    <= d_wr;
                    end else begin
                        tbl_q <= d_next;
                        lvl_q <= lvl_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_req_o  = (state_q == ST_READ_REQ);
    assign rd_addr_o = tbl_q + off;
    assign done_o    = (state_q == ST_DONE);
    assign fault_o   = fault_q;
    assign pa_o      = pa_q;
    assign pmask_o   = pmask_q;
    assign wr_ok_o   = wr_q;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk #(
    parameter int AW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    gran_i,
    input logic [5:0]    tsz_i,
    input logic [AW-1:0] va_i,
    input logic          rd_req_o,
    input logic [2:0]    rd_addr_lo,
    input logic          rd_ack_i,
    input logic          done_o,
    input logic          fault_o,
    input logic [AW-1:0] pa_o,
    input logic [AW-1:0] pmask_o,
    input logic          wr_ok_o
);
    logic          busy, outst;
    logic [AW-1:0] va_cap;
    logic          cfg_ok;

    always_comb begin
        case (gran_i)
            2'd0:    cfg_ok = (tsz_i >= 6'd16) && (tsz_i <= 6'd39);
            2'd1:    cfg_ok = (tsz_i >= 6'd16) && (tsz_i <= 6'd39);
            2'd2:    cfg_ok = (tsz_i >= 6'd12) && (tsz_i <= 6'd39);
            default: cfg_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            outst  <= 1'b0;
            va_cap <= '0;
        end else begin
            if (done_o) busy <= 1'b0;
            else if (start_i && !busy) begin
                busy   <= 1'b1;
                va_cap <= va_i;
            end
            if (rd_req_o)      outst <= 1'b1;
            else if (rd_ack_i) outst <= 1'b0;
        end
    end

    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !outst);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_bad_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && !done_o && !cfg_ok) |=> (done_o && fault_o));
    p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (pa_o == '0 && pmask_o == '0 && !wr_ok_o));
    p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> ($countones(pmask_o ^ (pmask_o << 1)) == 1 && pmask_o[11:0] == 12'd0));
    p_va_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> (((pa_o ^ va_cap) & ~pmask_o) == '0));
    p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_lo == 3'd0));
endmodule

bind xlat_walker xw_walker_chk #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .gran_i     (gran_i),
    .tsz_i      (tsz_i),
    .va_i       (va_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_lo (rd_addr_o[2:0]),
    .rd_ack_i   (rd_ack_i),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .pa_o       (pa_o),
    .pmask_o    (pmask_o),
    .wr_ok_o    (wr_ok_o)
);

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] va_i = '0, base_i = '0;
    logic [1:0]  gran_i = '0;
    logic [5:0]  tsz_i = '0;
    logic        stage2_i = 1'b0;
    logic        rd_req_o, rd_ack_i = 1'b0, rd_err_i = 1'b0;
    logic [47:0] rd_addr_o;
    logic [63:0] rd_data_i = '0;
    logic        done_o, fault_o, wr_ok_o;
    logic [47:0] pa_o, pmask_o;

    always #2.5 clk = ~clk;

    xlat_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .base_i(base_i),
        .gran_i(gran_i), .tsz_i(tsz_i), .stage2_i(stage2_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .rd_err_i(rd_err_i), .done_o(done_o),
        .fault_o(fault_o), .pa_o(pa_o), .pmask_o(pmask_o), .wr_ok_o(wr_ok_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [63:0] mem  [logic [47:0]];
    bit          errs [logic [47:0]];
    logic [47:0] exp_q [$];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lsb_of(int g, int l);
        if (g == 0) return 39 - 9 * l;
        if (g == 1) return (l == 0) ? 47 : 47 - 11 * l;
        return 55 - 13 * l;
    endfunction

    function automatic int wid_of(int g, int l);
        if (g == 0) return 9;
        if (g == 1) return (l == 0) ? 1 : 11;
        return (l == 1) ? 6 : 13;
    endfunction

    function automatic logic [47:0] slot(int g, int l, logic [47:0] tbl, logic [47:0] va);
        logic [47:0] idx;
        idx = (va >> lsb_of(g, l)) & ((48'h1 << wid_of(g, l)) - 48'h1);
        return tbl + (idx << 3);
    endfunction

    function automatic int first_of(int g, int t);
        if (g == 0) begin
            if (t >= 16 && t <= 24) return 0;
            if (t >= 25 && t <= 33) return 1;
            if (t >= 34 && t <= 39) return 2;
        end else if (g == 1) begin
            if (t == 16) return 0;
            if (t >= 17 && t <= 27) return 1;
            if (t >= 28 && t <= 38) return 2;
            if (t == 39) return 3;
        end else if (g == 2) begin
            if (t >= 12 && t <= 21) return 1;
            if (t >= 22 && t <= 34) return 2;
            if (t >= 35 && t <= 39) return 3;
        end
        return -1;
    endfunction

    // behavioural walk: fills exp_q with the read addresses
    function automatic void ref_walk(int g, int t, logic [47:0] va, logic [47:0] base, bit s2,
                                     output bit flt, output logic [47:0] pa,
                                     output logic [47:0] msk, output bit wr, output int n);
        int lvl, w;
        logic [47:0] tbl, a;
        logic [63:0] d;
        bit leaf;
        flt = 1'b1; pa = '0; msk = '0; wr = 1'b0; n = 0;
        lvl = first_of(g, t);
        if (lvl < 0) return;
        tbl = base;
        forever begin
            a = slot(g, lvl, tbl, va);
            exp_q.push_back(a);
            n++;
            if (errs.exists(a)) return;
            d = mem.exists(a) ? mem[a] : 64'h0;
            if (!d[0] || (lvl == 3 && !d[1])) return;
            leaf = (lvl == 3) || (!d[1] && lvl >= 1 && !(lvl == 1 && g != 0));
            if (!leaf) begin
                tbl = d[47:0] & ~((48'h1 << lsb_of(g, 3)) - 48'h1);
                lvl++;
            end else begin
                w = lsb_of(g, lvl);
                if (d[52]) begin
                    if (g == 0 && lvl == 3) w = 16;
                    if (g == 1 && lvl == 2) w = 30;
                    if (g == 1 && lvl == 3) w = 21;
                    if (g == 2 && lvl == 3) w = 21;
                end
                msk = ~((48'h1 << w) - 48'h1);
                pa  = (d[47:0] & msk) | (va & ~msk);
                wr  = s2 ? (d[7:6] == 2'b11) : !d[7];
                flt = 1'b0;
                return;
            end
        end
    endfunction

    task automatic walk(int g, int t, logic [47:0] va, logic [47:0] base, bit s2,
                        int lat, bit poke, string req);
        bit eflt, ewr;
        logic [47:0] epa, emsk, ra;
        int n, edone, pend;
        exp_q.delete();
        ref_walk(g, t, va, base, s2, eflt, epa, emsk, ewr, n);
        edone = n * (lat + 2) + 1;
        pend = 0;
        ra = '0;
        @(negedge clk);
        start_i = 1'b1; gran_i = 2'(g); tsz_i = 6'(t); va_i = va; base_i = base; stage2_i = s2;
        for (int c = 1; c <= edone + 4; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (poke && c == 2) begin
                start_i = 1'b1; tsz_i = 6'd63; va_i = ~va; gran_i = 2'd3;
            end
            rd_ack_i = 1'b0; rd_err_i = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = mem.exists(ra) ? mem[ra] : 64'h0;
                    rd_err_i  = errs.exists(ra);
                end
            end
            if (rd_req_o) begin
                if (exp_q.size() == 0) chk(1'b0, "R10", "extra read", 64'(rd_addr_o), 64'h0);
                else begin
                    logic [47:0] ea;
                    ea = exp_q.pop_front();
                    chk(rd_addr_o == ea, "R2/R5", "read address", 64'(rd_addr_o), 64'(ea));
                end
                ra = rd_addr_o;
                pend = lat;
            end
            chk(done_o == (c == edone), req, "done timing (R10)", 64'(done_o), 64'(c == edone));
            if (c == edone) begin
                chk(fault_o == eflt, req, "fault", 64'(fault_o), 64'(eflt));
                chk(pa_o == epa, req, "pa", 64'(pa_o), 64'(epa));
                chk(pmask_o == emsk, req, "mask", 64'(pmask_o), 64'(emsk));
                chk(wr_ok_o == ewr, req, "writable", 64'(wr_ok_o), 64'(ewr));
            end
        end
        chk(exp_q.size() == 0, "R10", "reads missing", 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] va, b, t1, t2, t3;
        b  = 48'h0000_0010_0000;
        t1 = 48'h0000_0020_0000;
        t2 = 48'h0000_0030_0000;
        t3 = 48'h0000_0040_0000;
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0 && rd_req_o == 1'b0, "R10", "reset idle", 64'({done_o, rd_req_o}), 64'h0);
        rst_n = 1'b1;

        // R4 R5 R8: 4 KB full walk level 0 to 3, stage-1 writable
        va = 48'h8123_4567_89AB;
        mem.delete(); errs.delete();
        mem[slot(0, 0, b, va)]  = 64'(t1) | 64'h3;
        mem[slot(0, 1, t1, va)] = 64'(t2) | 64'h3;
        mem[slot(0, 2, t2, va)] = 64'(t3) | 64'h3;
        mem[slot(0, 3, t3, va)] = 64'h0000_00AB_CDEF_5003;
        walk(0, 16, va, b, 1'b0, 1, 1'b0, "R4");

        // R11: same walk with a start pulse while busy
        walk(0, 16, va, b, 1'b0, 2, 1'b1, "R11");

        // R8: 4 KB 1 GB block at level 1, stage-2 writable
        mem.delete();
        mem[slot(0, 1, b, va)] = 64'h0000_0040_0000_00C1;
        walk(0, 25, va, b, 1'b1, 2, 1'b0, "R8");

        // R6: 4 KB 2 MB block at level 2, stage-2 not writable
        mem.delete();
        mem[slot(0, 2, b, va)] = 64'h0000_0060_0020_0041;
        walk(0, 34, va, b, 1'b1, 3, 1'b0, "R6");

        // R7: 4 KB level 3 with contiguous hint
        mem.delete();
        mem[slot(0, 2, b, va)]  = 64'(t1) | 64'h3;
        mem[slot(0, 3, t1, va)] = 64'h0010_0000_7777_F003;
        walk(0, 34, va, b, 1'b0, 1, 1'b0, "R7");

        // R4: 16 KB, level-1 entry with bit 1 clear is still a table; contiguous L2
        va = 48'h7FED_CBA9_8765;
        mem.delete();
        mem[slot(1, 0, b, va)]  = 64'(t1) | 64'h3;
        mem[slot(1, 1, t1, va)] = 64'(t2) | 64'h1;
        mem[slot(1, 2, t2, va)] = 64'h0010_0001_4000_0001;
        walk(1, 16, va, b, 1'b0, 2, 1'b0, "R4");

        // R7: 16 KB start at level 3, contiguous
        mem.delete();
        mem[slot(1, 3, b, va)] = 64'h0010_1234_5678_C003;
        walk(1, 39, va, b, 1'b0, 1, 1'b0, "R7");

        // R5: 64 KB, level 1 bit 1 clear is a table, level 2 block stage-2
        va = 48'hA5A5_5A5A_3C3C;
        mem.delete();
        mem[slot(2, 1, b, va)]  = 64'(t1) | 64'h1;
        mem[slot(2, 2, t1, va)] = 64'h0000_0000_C000_00C1;
        walk(2, 12, va, b, 1'b1, 2, 1'b0, "R5");

        // R8: 64 KB level 3 contiguous, stage-1 bit 7 set
        mem.delete();
        mem[slot(2, 3, b, va)] = 64'h0010_0000_0ABC_0083;
        walk(2, 35, va, b, 1'b0, 5, 1'b0, "R8");

        // R3: invalid level-2 entry, then level-3 entry missing bit 1
        mem.delete();
        mem[slot(0, 2, b, va)] = 64'(t1) | 64'h2;
        walk(0, 34, va, b, 1'b0, 1, 1'b0, "R3");
        mem.delete();
        mem[slot(1, 3, b, va)] = 64'h0000_0000_1234_4001;
        walk(1, 39, va, b, 1'b0, 2, 1'b0, "R3");

        // R9: error response on the second read
        mem.delete();
        mem[slot(0, 1, b, va)]  = 64'(t1) | 64'h3;
        mem[slot(0, 2, t1, va)] = 64'h0000_0000_4020_0001;
        errs[slot(0, 2, t1, va)] = 1'b1;
        walk(0, 25, va, b, 1'b0, 2, 1'b0, "R9");
        errs.delete();

        // R1: rejected configurations, no reads
        walk(0, 40, va, b, 1'b0, 1, 1'b0, "R1");
        walk(1, 15, va, b, 1'b0, 1, 1'b0, "R1");
        walk(2, 11, va, b, 1'b0, 1, 1'b0, "R1");
        walk(3, 20, va, b, 1'b0, 1, 1'b0, "R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule